// File: doc/BRIEF.md
# Speculative Parallel Instruction Boundary Finder

This block receives a fixed-size fetch block of instruction bytes and reports where each variable-length instruction in it begins. The encoding is simplified. The top two bits of an instruction's first byte give its length: 00 gives 1 byte, 01 gives 2, 10 gives 3 and 11 gives 4. A separate length unit sits at every byte offset, and each unit assumes that an instruction starts at its own offset. All of these units work at once. A serial selection chain then walks their results from the current start offset. It keeps only the lengths that lie on true boundaries and discards the rest.

Each cycle, up to `MAX_OUT` instructions leave the block as slots. Each slot is a valid bit, a 4-bit start offset and a 3-bit length, and the slots fill from slot 0 in program order. Some instructions run past the end of the block. Such an instruction is not emitted in that block. It is held and reported in slot 0 of the first cycle of the next accepted block, with its original offset and its full length. The chain in that next block starts right after the tail bytes. When a block holds more boundaries than one cycle can carry, `blk_ready_o` stays low and the rest are reported on the following cycles.

Top module: `bnd_finder`

## Requirements
- R1: The length of each emitted instruction is the top two bits of its first byte plus one (00→1, 01→2, 10→3, 11→4).
- R2: Valid slots are contiguous from slot 0. The first instruction found in a block starts at the block's start offset.
- R3: In an emitted slot, each start offset equals the previous slot's start plus that slot's length, taken modulo 16. Offsets not on this chain produce no slot.
- R4: An instruction whose end would pass byte 15 is not emitted in its own block. In the first cycle of the next block, slot 0 carries it with its original start and full length. That block's chain then begins at (start + length − 16).
- R5: At most `MAX_OUT` (default 6) slots are valid per cycle. If boundaries remain after a full cycle, `blk_ready_o` is low and the block is held. The remaining boundaries come out on later cycles, and `blk_ready_o` goes high in the cycle that reports the last of them.
- R6: While `flush_i` is high, no slot is valid and `blk_ready_o` is low. The next block after a flush starts at offset 0 with no held instruction.
- R7: After reset, the start offset is 0 and no instruction is held.
- R8: When `blk_valid_i` is low, no slot is valid and the internal state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Drops the held instruction and the pending position |
| blk_valid_i | input | 1 | Fetch block present |
| blk_ready_o | output | 1 | The block is fully consumed this cycle |
| blk_data_i | input | 128 | Fetch block; byte i is at bits [8i+7:8i] |
| out_valid_o | output | 6 | Per-slot valid bits |
| out_start_o | output | 24 | Per-slot start offset, 4 bits per slot |
| out_len_o | output | 18 | Per-slot length, 3 bits per slot |

## Verification
Blocks made only of 1-byte instructions produce 16 boundaries. These show whether the block is held for the right number of cycles and whether the resume offset is kept. Blocks made only of 4-byte and only of 3-byte instructions test the chain stride, and the 3-byte pattern leaves an instruction hanging at offset 15. That exposes the carry path, and a following block of 2-byte instructions both fills every slot and needs holding. Flushes issued during a hold and during a pending carry, together with random bytes, random valid gaps and random flushes, separate a correct restart from stale state.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  localparam int unsigned LEN_W = 3;

  function automatic logic [LEN_W-1:0] insn_len(input logic [7:0] first_byte);
    return {1'b0, first_byte[7:6]} + 3'd1;
  endfunction
endpackage

// File: rtl/bnd_len_unit.sv
module bnd_len_unit
  import bnd_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 16,
  parameter int unsigned OFFS        = 0
) (
  input  logic [BLOCK_BYTES*8-1:0] blk_i,
  output logic [LEN_W-1:0]         len_o,
  output logic                     fits_o
);
  // assumes an instruction begins at OFFS; looks only at its own byte
  assign len_o  = insn_len(blk_i[OFFS*8 +: 8]);
  assign fits_o = (32'(OFFS) + 32'(len_o)) <= 32'(BLOCK_BYTES);
endmodule

// File: rtl/bnd_chain.sv
module bnd_chain
  import bnd_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 16,
  parameter int unsigned MAX_OUT     = 6,
  localparam int unsigned OW = $clog2(BLOCK_BYTES),
  localparam int unsigned PW = OW + 1
) (
  input  logic [BLOCK_BYTES-1:0][LEN_W-1:0] lens_i,
  input  logic [BLOCK_BYTES-1:0]            fits_i,
  input  logic [PW-1:0]                     pos_i,
  input  logic                              carry_i,
  input  logic [OW-1:0]                     carry_start_i,
  input  logic [LEN_W-1:0]                  carry_len_i,
  output logic [MAX_OUT-1:0]                vld_o,
  output logic [MAX_OUT-1:0][OW-1:0]        start_o,
  output logic [MAX_OUT-1:0][LEN_W-1:0]     len_o,
  output logic                              done_o,
  output logic [PW-1:0]                     end_o,
  output logic                              part_o,
  output logic [OW-1:0]                     part_start_o,
  output logic [LEN_W-1:0]                  part_len_o
);
  localparam logic [PW-1:0] BLK = PW'(BLOCK_BYTES);

  logic [PW-1:0] p;
  logic [OW-1:0] pi;

  always_comb begin
    p       = pos_i;
    vld_o   = '0;
    start_o = '0;
    len_o   = '0;
    for (int s = 0; s < MAX_OUT; s++) begin
      pi = p[OW-1:0];
      if (s == 0 && carry_i) begin
        vld_o[0]   = 1'b1;
        start_o[0] = carry_start_i;
        len_o[0]   = carry_len_i;
      end else if (p < BLK && fits_i[pi]) begin
        vld_o[s]   = 1'b1;
        start_o[s] = pi;
        len_o[s]   = lens_i[pi];
        p          = p + PW'(lens_i[pi]);
      end
    end
    pi           = p[OW-1:0];
    part_start_o = pi;
    part_len_o   = lens_i[pi];
    if (p >= BLK) begin
      done_o = 1'b1;
      part_o = 1'b0;
      end_o  = p;
    end else if (!fits_i[pi]) begin
      done_o = 1'b1;
      part_o = 1'b1;
      end_o  = p + PW'(lens_i[pi]);
    end else begin
      done_o = 1'b0;
      part_o = 1'b0;
      end_o  = p;
    end
  end
endmodule

// File: rtl/bnd_finder.sv
module bnd_finder
  import bnd_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 16,
  parameter int unsigned MAX_OUT     = 6
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  flush_i,
  input  logic                                  blk_valid_i,
  output logic                                  blk_ready_o,
  input  logic [BLOCK_BYTES*8-1:0]              blk_data_i,
  output logic [MAX_OUT-1:0]                    out_valid_o,
  output logic [MAX_OUT*$clog2(BLOCK_BYTES)-1:0] out_start_o,
  output logic [MAX_OUT*LEN_W-1:0]              out_len_o
);
  localparam int unsigned OW = $clog2(BLOCK_BYTES);
  localparam int unsigned PW = OW + 1;
  localparam logic [PW-1:0] BLK = PW'(BLOCK_BYTES);

  logic [BLOCK_BYTES-1:0][LEN_W-1:0] lens;
  logic [BLOCK_BYTES-1:0]            fits;

  for (genvar i = 0; i < BLOCK_BYTES; i++) begin : g_len
    bnd_len_unit #(.BLOCK_BYTES(BLOCK_BYTES), .OFFS(i)) u_len (
      .blk_i  (blk_data_i),
      .len_o  (lens[i]),
      .fits_o (fits[i])
    );
  end

  logic [PW-1:0]    pos_q;
  logic             carry_q;
  logic [OW-1:0]    cst_q;
  logic [LEN_W-1:0] cln_q;

  logic [MAX_OUT-1:0]            vld;
  logic [MAX_OUT-1:0][OW-1:0]    st;
  logic [MAX_OUT-1:0][LEN_W-1:0] ln;
  logic                          done, part;
  logic [PW-1:0]                 end_pos;
  logic [OW-1:0]                 part_st;
  logic [LEN_W-1:0]              part_ln;

  bnd_chain #(.BLOCK_BYTES(BLOCK_BYTES), .MAX_OUT(MAX_OUT)) u_chain (
    .lens_i        (lens),
    .fits_i        (fits),
    .pos_i         (pos_q),
    .carry_i       (carry_q),
    .carry_start_i (cst_q),
    .carry_len_i   (cln_q),
    .vld_o         (vld),
    .start_o       (st),
    .len_o         (ln),
    .done_o        (done),
    .end_o         (end_pos),
    .part_o        (part),
    .part_start_o  (part_st),
    .part_len_o    (part_ln)
  );

  logic live;
  assign live        = blk_valid_i && !flush_i;
  assign blk_ready_o = !flush_i && done;

  for (genvar s = 0; s < MAX_OUT; s++) begin : g_out
    assign out_valid_o[s]               = live && vld[s];
    assign out_start_o[s*OW +: OW]      = out_valid_o[s] ? st[s] : '0;
    assign out_len_o[s*LEN_W +: LEN_W]  = out_valid_o[s] ? ln[s] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      carry_q <= 1'b0;
      cst_q   <= '0;
      cln_q   <= '0;
    end else if (flush_i) begin
      pos_q   <= '0;
      carry_q <= 1'b0;
      cst_q   <= '0;
      cln_q   <= '0;
    end else if (blk_valid_i) begin
      if (done) begin
        // block consumed: next block resumes after any spilled tail
        pos_q   <= end_pos - BLK;
        carry_q <= part;
        cst_q   <= part_st;
        cln_q   <= part_ln;
      end else begin
        pos_q   <= end_pos;
        carry_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bnd_finder_chk.sv
module bnd_finder_chk
  import bnd_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 16,
  parameter int unsigned MAX_OUT     = 6
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   flush_i,
  input logic                                   blk_valid_i,
  input logic                                   blk_ready_o,
  input logic [BLOCK_BYTES*8-1:0]               blk_data_i,
  input logic [MAX_OUT-1:0]                     out_valid_o,
  input logic [MAX_OUT*$clog2(BLOCK_BYTES)-1:0] out_start_o,
  input logic [MAX_OUT*LEN_W-1:0]               out_len_o
);
  localparam int unsigned OW = $clog2(BLOCK_BYTES);

  logic [MAX_OUT-1:0] vplus;
  assign vplus = out_valid_o + MAX_OUT'(1);

  p_slots_packed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o & vplus) == '0);

  p_narrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && !flush_i && !blk_ready_o) |-> (&out_valid_o));

  p_flush_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (out_valid_o == '0 && !blk_ready_o));

  p_flush_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (flush_i || !out_valid_o[0] || out_start_o[OW-1:0] == '0));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_valid_i |-> (out_valid_o == '0));

  for (genvar s = 0; s < MAX_OUT; s++) begin : g_slot
    logic [LEN_W-1:0] l;
    assign l = out_len_o[s*LEN_W +: LEN_W];

    p_len_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[s] |-> (l >= 3'd1 && l <= 3'd4));

    if (s > 0) begin : g_link
      logic [OW-1:0] prev_next;
      logic [OW:0]   end_here;
      assign prev_next = out_start_o[(s-1)*OW +: OW] + OW'(out_len_o[(s-1)*LEN_W +: LEN_W]);
      assign end_here  = {1'b0, out_start_o[s*OW +: OW]} + (OW+1)'(l);

      p_chain_link_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o[s] |-> (out_start_o[s*OW +: OW] == prev_next));

      p_in_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o[s] |-> (end_here <= (OW+1)'(BLOCK_BYTES)));
    end
  end
endmodule

bind bnd_finder bnd_finder_chk #(.BLOCK_BYTES(BLOCK_BYTES), .MAX_OUT(MAX_OUT)) u_chk (.*);

// File: tb/bnd_finder_test.sv
module bnd_finder_test;
  localparam int NB = 16;
  localparam int NO = 6;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           flush_i = 1'b0;
  logic           blk_valid_i = 1'b0;
  logic           blk_ready_o;
  logic [NB*8-1:0] blk_data_i = '0;
  logic [NO-1:0]  out_valid_o;
  logic [NO*4-1:0] out_start_o;
  logic [NO*3-1:0] out_len_o;

  always #4 clk = ~clk;

  bnd_finder #(.BLOCK_BYTES(NB), .MAX_OUT(NO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .blk_valid_i(blk_valid_i), .blk_ready_o(blk_ready_o), .blk_data_i(blk_data_i),
    .out_valid_o(out_valid_o), .out_start_o(out_start_o), .out_len_o(out_len_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  int m_pos = 0;
  bit m_carry = 0;
  int m_cs = 0;
  int m_cl = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int blen(input logic [NB*8-1:0] d, input int p);
    logic [7:0] b;
    b = d[8*p +: 8];
    return int'(b[7:6]) + 1;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(input logic v, input logic f, input logic [NB*8-1:0] d, input string tag);
    int p, L, ev[NO], es[NO], el[NO];
    bit done, part;
    string rq;
    @(negedge clk);
    blk_valid_i = v;
    flush_i = f;
    blk_data_i = d;
    #1;
    p = m_pos;
    for (int s = 0; s < NO; s++) begin
      ev[s] = 0; es[s] = 0; el[s] = 0;
      if (s == 0 && m_carry) begin
        ev[0] = 1; es[0] = m_cs; el[0] = m_cl;
      end else if (p < NB) begin
        L = blen(d, p);
        if (p + L <= NB) begin
          ev[s] = 1; es[s] = p; el[s] = L; p += L;
        end
      end
    end
    L = (p < NB) ? blen(d, p) : 0;
    part = (p < NB) && (p + L > NB);
    done = (p >= NB) || part;
    chk(f ? "R6" : "R5", {tag, " ready"}, int'(blk_ready_o), int'(!f && done));
    for (int s = 0; s < NO; s++) begin
      if (!v || f) begin ev[s] = 0; es[s] = 0; el[s] = 0; end
      if (f) rq = "R6";
      else if (!v) rq = "R8";
      else if (s == 0 && m_carry) rq = "R4";
      else rq = "";
      chk(rq == "" ? "R2" : rq, $sformatf("%s slot%0d valid", tag, s), int'(out_valid_o[s]), ev[s]);
      chk(rq == "" ? "R3" : rq, $sformatf("%s slot%0d start", tag, s), int'(out_start_o[s*4 +: 4]), es[s]);
      chk(rq == "" ? "R1" : rq, $sformatf("%s slot%0d len", tag, s), int'(out_len_o[s*3 +: 3]), el[s]);
    end
    if (f) begin
      m_pos = 0; m_carry = 0; m_cs = 0; m_cl = 0;
    end else if (v) begin
      if (done) begin
        m_carry = part;
        if (part) begin m_cs = p; m_cl = L; m_pos = p + L - NB; end
        else m_pos = p - NB;
      end else begin
        m_pos = p; m_carry = 0;
      end
    end
  endtask

  function automatic logic [NB*8-1:0] fill(input logic [7:0] b);
    logic [NB*8-1:0] d;
    for (int i = 0; i < NB; i++) d[8*i +: 8] = b;
    return d;
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [NB*8-1:0] d;
    void'($urandom(32'd20240611));
    #20;
    rst_ni = 1'b1;
    // R7: reset state, start at 0; all-4-byte block fits in one pass
    @(negedge clk);
    blk_data_i = fill(8'hC0);
    #1;
    chk("R7", "reset ready", int'(blk_ready_o), 1);
    chk("R8", "idle valid", int'(out_valid_o), 0);
    step(1, 0, fill(8'hC0), "R7 four-byte");
    // R5: 16 one-byte instructions -> 6,6,4
    step(1, 0, fill(8'h00), "R5 ones a");
    step(1, 0, fill(8'h00), "R5 ones b");
    step(1, 0, fill(8'h00), "R5 ones c");
    step(0, 0, fill(8'h00), "R8 idle");
    // R4: 3-byte stride leaves one at offset 15
    step(1, 0, fill(8'h80), "R4 threes");
    step(0, 0, fill(8'hFF), "R8 idle carry");
    step(1, 0, fill(8'h40), "R4 twos a");
    step(1, 0, fill(8'h40), "R4 twos b");
    // R6: flush while holding
    step(1, 0, fill(8'h00), "R6 pre");
    step(1, 1, fill(8'h00), "R6 flush hold");
    step(1, 0, fill(8'hC0), "R6 after");
    // R6: flush with carry pending
    step(1, 0, fill(8'h80), "R6 carry");
    step(0, 1, fill(8'h80), "R6 flush carry");
    step(1, 0, fill(8'h40), "R6 restart");
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NB; i++) d[8*i +: 8] = 8'($urandom);
      step(($urandom % 4) != 0, ($urandom % 32) == 0, d, "rand");
    end
    summary();
  end
endmodule